// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block walks the current address of a DMA channel through a one- or two-dimensional element pattern. Software (or a descriptor fetcher) presents the start address, X and Y element counts, signed 16-bit X and Y modify values, a 2D enable, a flow mode and a row-interrupt enable, and pulses `load_i`. From then on, each cycle in which the data mover accepts an element (`elem_ack_i`) advances the address and counters by one element.

At the last element of a row the block can raise a one-cycle row interrupt. In 2D mode, while rows remain, the row end reloads the X counter, decrements the Y counter and applies the Y modify in place of the X modify. At the last element of the whole transfer, stop flow clears RUN and pulses the DONE-set and RUN-clear strobes. Every other flow mode raises a reload request that holds until the next load. Memory access, element-size checking and descriptor fetching belong to neighbouring blocks.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `cur_addr_o`, `cur_x_o` and `cur_y_o` are 0, and `run_o`, `reload_req_o`, `row_irq_o`, `done_set_o` and `run_clr_o` are low.
- R2: On the edge where `load_i` is high, the block takes the start address into `cur_addr_o` and the programmed X and Y counts into `cur_x_o` and `cur_y_o`, mapping a programmed count of 0 to 0xFFFF. The same edge sets `run_o` and clears `reload_req_o`. `load_i` has priority over `elem_ack_i`.
- R3: An accepted element that is not the last of its row adds the sign-extended X modify to the address and decrements `cur_x_o` by one.
- R4: In 2D mode (`mode_2d_i`=1), an accepted last element of a row with `cur_y_o` greater than 1 adds the Y modify (and no X modify) to the address, decrements `cur_y_o` and reloads `cur_x_o` with the programmed X count.
- R5: The last element of the transfer adds the X modify and sets `cur_x_o` to 0. This is any row end in 1D mode, or a row end with `cur_y_o` of at most 1 in 2D mode. `cur_y_o` keeps its value.
- R6: `row_irq_o` is high for exactly the one cycle after every accepted row-end element when the row-interrupt enable was set at load. It never rises when that enable is clear.
- R7: With flow code 0 (stop), the transfer end clears `run_o` and drives `done_set_o` and `run_clr_o` high for exactly one cycle.
- R8: With flow codes 1, 2 or 3, the transfer end raises `reload_req_o` and keeps `run_o` high. `reload_req_o` stays high until the next `load_i`.
- R9: `elem_ack_i` has no effect on the address, the counts or any strobe while `run_o` is low or `reload_req_o` is high.
- R10: In 1D mode, `cur_y_o` keeps its loaded value and the transfer ends after one row of X elements.
- R11: Modify values are 16-bit two's complement, sign-extended to the 32-bit address. Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Take the programmed registers and start the channel |
| start_addr_i | input | 32 | Start address |
| x_count_i | input | 16 | Elements per row (0 means 0xFFFF) |
| x_mod_i | input | 16 | Signed per-element address step |
| y_count_i | input | 16 | Rows in 2D mode (0 means 0xFFFF) |
| y_mod_i | input | 16 | Signed step applied at a row end in 2D mode |
| mode_2d_i | input | 1 | 1 selects two-dimensional mode |
| flow_i | input | 2 | Flow mode: 0 stop, other codes request a reload |
| irq_en_i | input | 1 | Row-end interrupt enable |
| elem_ack_i | input | 1 | Data mover accepted one element this cycle |
| cur_addr_o | output | 32 | Current element address |
| cur_x_o | output | 16 | Remaining elements in the current row |
| cur_y_o | output | 16 | Remaining rows |
| run_o | output | 1 | Channel running |
| row_irq_o | output | 1 | One-cycle row interrupt pulse |
| done_set_o | output | 1 | One-cycle pulse to set DONE status |
| run_clr_o | output | 1 | One-cycle pulse marking RUN cleared |
| reload_req_o | output | 1 | Next-descriptor request, held until load |

## Verification
A wrong X or Y counter shows up at the ports on the first element after the fault. The row end comes early or late, so `row_irq_o` and the Y-modify jump in `cur_addr_o` appear one or more elements away from where they belong. A wrong address path is visible one cycle after the accepted element, since `cur_addr_o` is a register updated on the acceptance edge. A wrong end-of-transfer decision shows up in the cycle after the last element: `run_o`, `done_set_o` or `reload_req_o` are wrong there. A missing ignore gate shows up as an address that keeps moving after that cycle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  parameter int ADDR_W = 32;
  parameter int CNT_W  = 16;
  parameter int MOD_W  = 16;
  parameter int FLOW_W = 2;

  typedef enum logic [FLOW_W-1:0] {
    FLOW_HALT  = 2'd0,
    FLOW_LOOP  = 2'd1,
    FLOW_CHAIN = 2'd2,
    FLOW_LIST  = 2'd3
  } flow_e;

  // Programmed count of zero stands for the largest count.
  function automatic logic [CNT_W-1:0] count_init(input logic [CNT_W-1:0] c);
    return (c == '0) ? '1 : c;
  endfunction

  // Two's complement modify widened to the address width.
  function automatic logic [ADDR_W-1:0] sext_mod(input logic [MOD_W-1:0] m);
    return {{(ADDR_W-MOD_W){m[MOD_W-1]}}, m};
  endfunction

  // One element step: the row wrap replaces the X step with the Y step.
  function automatic logic [ADDR_W-1:0] addr_advance(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] xm,
    input logic [ADDR_W-1:0] ym,
    input logic              wrap
  );
    return wrap ? (a + ym) : (a + xm);
  endfunction

endpackage

// File: rtl/dma2d_cfg_regs.sv
module dma2d_cfg_regs
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  x_count_i,
  input  logic [MOD_W-1:0]  x_mod_i,
  input  logic [MOD_W-1:0]  y_mod_i,
  input  logic              mode_2d_i,
  input  logic [FLOW_W-1:0] flow_i,
  input  logic              irq_en_i,
  output logic [CNT_W-1:0]  x_rld_o,
  output logic [ADDR_W-1:0] xm_ext_o,
  output logic [ADDR_W-1:0] ym_ext_o,
  output logic              mode_2d_o,
  output logic              halt_o,
  output logic              irq_en_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_rld_o   <= '0;
      xm_ext_o  <= '0;
      ym_ext_o  <= '0;
      mode_2d_o <= 1'b0;
      halt_o    <= 1'b1;
      irq_en_o  <= 1'b0;
    end else if (load_i) begin
      x_rld_o   <= count_init(x_count_i);
      xm_ext_o  <= sext_mod(x_mod_i);
      ym_ext_o  <= sext_mod(y_mod_i);
      mode_2d_o <= mode_2d_i;
      halt_o    <= (flow_i == FLOW_HALT);
      irq_en_o  <= irq_en_i;
    end
  end

endmodule

// File: rtl/dma2d_xy_count.sv
module dma2d_xy_count
  import dma2d_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] x_count_i,
  input  logic [CNT_W-1:0] y_count_i,
  input  logic             step_i,
  input  logic             mode_2d_i,
  input  logic [CNT_W-1:0] x_rld_i,
  output logic [CNT_W-1:0] cur_x_o,
  output logic [CNT_W-1:0] cur_y_o,
  output logic             row_end_o,
  output logic             last_row_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign row_end_o  = step_i && (cur_x_o == ONE);
  assign last_row_o = !mode_2d_i || (cur_y_o <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_x_o <= '0;
      cur_y_o <= '0;
    end else if (load_i) begin
      cur_x_o <= count_init(x_count_i);
      cur_y_o <= count_init(y_count_i);
    end else if (step_i) begin
      if (row_end_o && !last_row_o) begin
        cur_x_o <= x_rld_i;
        cur_y_o <= cur_y_o - ONE;
      end else begin
        cur_x_o <= cur_x_o - ONE;
      end
    end
  end

endmodule

// File: rtl/dma2d_addr_step.sv
module dma2d_addr_step
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              step_i,
  input  logic              row_wrap_i,
  input  logic [ADDR_W-1:0] xm_ext_i,
  input  logic [ADDR_W-1:0] ym_ext_i,
  output logic [ADDR_W-1:0] cur_addr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_addr_o <= '0;
    else if (load_i)
      cur_addr_o <= start_addr_i;
    else if (step_i)
      cur_addr_o <= addr_advance(cur_addr_o, xm_ext_i, ym_ext_i, row_wrap_i);
  end

endmodule

// File: rtl/dma2d_flow_ctrl.sv
module dma2d_flow_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic elem_ack_i,
  input  logic row_end_i,
  input  logic last_row_i,
  input  logic halt_i,
  input  logic irq_en_i,
  output logic step_o,
  output logic run_o,
  output logic reload_req_o,
  output logic row_irq_o,
  output logic done_set_o,
  output logic run_clr_o
);

  logic xfer_end;

  assign step_o   = elem_ack_i && run_o && !reload_req_o && !load_i;
  assign xfer_end = row_end_i && last_row_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o        <= 1'b0;
      reload_req_o <= 1'b0;
      row_irq_o    <= 1'b0;
      done_set_o   <= 1'b0;
      run_clr_o    <= 1'b0;
    end else begin
      row_irq_o  <= row_end_i && irq_en_i;
      done_set_o <= xfer_end && halt_i;
      run_clr_o  <= xfer_end && halt_i;
      if (load_i) begin
        run_o        <= 1'b1;
        reload_req_o <= 1'b0;
      end else if (xfer_end) begin
        if (halt_i) run_o        <= 1'b0;
        else        reload_req_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  x_count_i,
  input  logic [MOD_W-1:0]  x_mod_i,
  input  logic [CNT_W-1:0]  y_count_i,
  input  logic [MOD_W-1:0]  y_mod_i,
  input  logic              mode_2d_i,
  input  logic [FLOW_W-1:0] flow_i,
  input  logic              irq_en_i,
  input  logic              elem_ack_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  cur_x_o,
  output logic [CNT_W-1:0]  cur_y_o,
  output logic              run_o,
  output logic              row_irq_o,
  output logic              done_set_o,
  output logic              run_clr_o,
  output logic              reload_req_o
);

  // Named internal events, visible to the bound checker.
  logic              step_w;
  logic              row_end_w;
  logic              last_row_w;
  logic              row_wrap_w;
  logic [CNT_W-1:0]  x_rld_w;
  logic [ADDR_W-1:0] xm_ext_w;
  logic [ADDR_W-1:0] ym_ext_w;
  logic              mode_2d_w;
  logic              halt_w;
  logic              irq_en_w;

  assign row_wrap_w = row_end_w && !last_row_w;

  dma2d_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .x_count_i (x_count_i),
    .x_mod_i   (x_mod_i),
    .y_mod_i   (y_mod_i),
    .mode_2d_i (mode_2d_i),
    .flow_i    (flow_i),
    .irq_en_i  (irq_en_i),
    .x_rld_o   (x_rld_w),
    .xm_ext_o  (xm_ext_w),
    .ym_ext_o  (ym_ext_w),
    .mode_2d_o (mode_2d_w),
    .halt_o    (halt_w),
    .irq_en_o  (irq_en_w)
  );

  dma2d_xy_count u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .x_count_i  (x_count_i),
    .y_count_i  (y_count_i),
    .step_i     (step_w),
    .mode_2d_i  (mode_2d_w),
    .x_rld_i    (x_rld_w),
    .cur_x_o    (cur_x_o),
    .cur_y_o    (cur_y_o),
    .row_end_o  (row_end_w),
    .last_row_o (last_row_w)
  );

  dma2d_addr_step u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .step_i       (step_w),
    .row_wrap_i   (row_wrap_w),
    .xm_ext_i     (xm_ext_w),
    .ym_ext_i     (ym_ext_w),
    .cur_addr_o   (cur_addr_o)
  );

  dma2d_flow_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .elem_ack_i   (elem_ack_i),
    .row_end_i    (row_end_w),
    .last_row_i   (last_row_w),
    .halt_i       (halt_w),
    .irq_en_i     (irq_en_w),
    .step_o       (step_w),
    .run_o        (run_o),
    .reload_req_o (reload_req_o),
    .row_irq_o    (row_irq_o),
    .done_set_o   (done_set_o),
    .run_clr_o    (run_clr_o)
  );

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk
  import dma2d_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              elem_ack_i,
  input logic              step_w,
  input logic              row_end_w,
  input logic              last_row_w,
  input logic              mode_2d_w,
  input logic              halt_w,
  input logic              irq_en_w,
  input logic [CNT_W-1:0]  x_rld_w,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic [CNT_W-1:0]  cur_x_o,
  input logic [CNT_W-1:0]  cur_y_o,
  input logic              run_o,
  input logic              row_irq_o,
  input logic              done_set_o,
  input logic              run_clr_o,
  input logic              reload_req_o
);

  // R3
  x_step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !row_end_w) |=> (cur_x_o == $past(cur_x_o) - CNT_W'(1)));

  // R4
  row_wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end_w && !last_row_w) |=> (cur_x_o == $past(x_rld_w)));

  // R6
  row_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_irq_o |-> $past(row_end_w && irq_en_w));

  // R7
  halt_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end_w && last_row_w && halt_w) |=> (done_set_o && run_clr_o && !run_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_set_o |=> !done_set_o);

  // R8
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_req_o && !load_i) |=> (reload_req_o && run_o));

  // R9
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_ack_i && (!run_o || reload_req_o) && !load_i) |=>
      ($stable(cur_addr_o) && $stable(cur_x_o) && $stable(cur_y_o)));

  // R10
  flat_y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !mode_2d_w) |=> $stable(cur_y_o));

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .elem_ack_i   (elem_ack_i),
  .step_w       (step_w),
  .row_end_w    (row_end_w),
  .last_row_w   (last_row_w),
  .mode_2d_w    (mode_2d_w),
  .halt_w       (halt_w),
  .irq_en_w     (irq_en_w),
  .x_rld_w      (x_rld_w),
  .cur_addr_o   (cur_addr_o),
  .cur_x_o      (cur_x_o),
  .cur_y_o      (cur_y_o),
  .run_o        (run_o),
  .row_irq_o    (row_irq_o),
  .done_set_o   (done_set_o),
  .run_clr_o    (run_clr_o),
  .reload_req_o (reload_req_o)
);

// File: tb/tb_dma2d_addr_gen.sv
`timescale 1ns/1ps
module tb_dma2d_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [15:0] x_count_i = '0, x_mod_i = '0, y_count_i = '0, y_mod_i = '0;
  logic        mode_2d_i = 1'b0;
  logic [1:0]  flow_i = '0;
  logic        irq_en_i = 1'b0;
  logic        elem_ack_i = 1'b0;
  logic [31:0] cur_addr_o;
  logic [15:0] cur_x_o, cur_y_o;
  logic        run_o, row_irq_o, done_set_o, run_clr_o, reload_req_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dma2d_addr_gen dut (.*);

  // Bench model of the programmed transfer.
  longint m_sa, m_xm, m_ym;
  int     m_x, m_y, m_rows, m_total, m_k;
  bit     m_2d, m_halt, m_ie, m_run, m_pend;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int k);
    longint a, rowstep;
    int r, c;
    rowstep = (m_x - 1) * m_xm + m_ym;
    if (k == m_total) begin
      a = m_sa + (m_rows - 1) * rowstep + m_x * m_xm;
    end else begin
      r = k / m_x;
      c = k % m_x;
      a = m_sa + r * rowstep + c * m_xm;
    end
    return a[31:0];
  endfunction

  function automatic logic [15:0] exp_x(input int k);
    if (k == m_total) return 16'd0;
    return 16'(m_x - (k % m_x));
  endfunction

  function automatic logic [15:0] exp_y(input int k);
    if (!m_2d) return 16'(m_y);
    if (k == m_total) return 16'd1;
    return 16'(m_y - (k / m_x));
  endfunction

  task automatic check_all(input string tag, input bit rend, input bit tend);
    check(tag, "addr", cur_addr_o, exp_addr(m_k));
    check(tag, "cur_x", {16'd0, cur_x_o}, {16'd0, exp_x(m_k)});
    check(m_2d ? tag : "R10", "cur_y", {16'd0, cur_y_o}, {16'd0, exp_y(m_k)});
    check("R6", "row_irq", {31'd0, row_irq_o}, {31'd0, rend && m_ie});
    check("R7", "done_set", {31'd0, done_set_o}, {31'd0, tend && m_halt});
    check("R7", "run_clr", {31'd0, run_clr_o}, {31'd0, tend && m_halt});
    check("R8", "run", {31'd0, run_o}, {31'd0, m_run});
    check("R8", "reload_req", {31'd0, reload_req_o}, {31'd0, m_pend});
  endtask

  // Load a transfer at a falling edge, then feed elements until it has
  // been idle for a few cycles or max_cyc cycles have passed.
  task automatic run_xfer(input logic [31:0] sa, input logic [15:0] xc,
                          input logic [15:0] xm, input logic [15:0] yc,
                          input logic [15:0] ym, input bit m2,
                          input logic [1:0] fl, input bit ie, input int max_cyc);
    int idle, cyc;
    bit acc, rend, tend, ack;
    string tag;
    start_addr_i = sa; x_count_i = xc; x_mod_i = xm;
    y_count_i = yc; y_mod_i = ym; mode_2d_i = m2; flow_i = fl;
    irq_en_i = ie; load_i = 1'b1; elem_ack_i = 1'b1;
    m_sa = longint'(sa);
    m_xm = longint'($signed(xm));
    m_ym = longint'($signed(ym));
    m_x = (xc == 0) ? 65535 : int'(xc);
    m_y = (yc == 0) ? 65535 : int'(yc);
    m_2d = m2; m_halt = (fl == 2'd0); m_ie = ie;
    m_rows = m2 ? m_y : 1;
    m_total = m_x * m_rows;
    @(negedge clk);
    load_i = 1'b0;
    m_k = 0; m_run = 1'b1; m_pend = 1'b0;
    check_all("R2", 1'b0, 1'b0);
    idle = 0; cyc = 0;
    while (idle < 4 && cyc < max_cyc) begin
      ack = ($urandom_range(0, 3) != 0);
      elem_ack_i = ack;
      acc = ack && m_run && !m_pend;
      @(negedge clk);
      cyc++;
      rend = 1'b0; tend = 1'b0;
      if (acc) begin
        m_k++;
        rend = (m_k % m_x) == 0;
        tend = (m_k == m_total);
        if (tend) begin
          if (m_halt) m_run = 1'b0;
          else        m_pend = 1'b1;
        end
      end
      if (tend)       tag = "R5";
      else if (rend)  tag = "R4";
      else if (acc)   tag = "R3";
      else            tag = "R9";
      check_all(tag, rend, tend);
      if (!m_run || m_pend) idle++;
    end
    elem_ack_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "addr", cur_addr_o, 32'd0);
    check("R1", "cur_x", {16'd0, cur_x_o}, 32'd0);
    check("R1", "flags", {27'd0, run_o, reload_req_o, row_irq_o, done_set_o, run_clr_o}, 32'd0);
    rst_n = 1'b1;
    // R9: strobe before any load has no effect
    elem_ack_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "addr idle", cur_addr_o, 32'd0);
    check("R9", "run idle", {31'd0, run_o}, 32'd0);
    elem_ack_i = 1'b0;

    // 1D, stop flow, interrupt on
    run_xfer(32'h0000_1000, 16'd4, 16'd4, 16'd7, 16'd0, 1'b0, 2'd0, 1'b1, 100);
    // 2D, chained flow, interrupt on
    run_xfer(32'h0000_2000, 16'd3, 16'd4, 16'd3, 16'd100, 1'b1, 2'd2, 1'b1, 100);
    // R11: negative modifies crossing zero
    run_xfer(32'h0000_0010, 16'd3, 16'hFFFC, 16'd2, 16'hFFE0, 1'b1, 2'd0, 1'b0, 100);
    check("R11", "final addr", cur_addr_o, 32'hFFFF_FFDC);
    // R2: zero counts map to 0xFFFF; reload while running
    run_xfer(32'h0000_4000, 16'd0, 16'd1, 16'd0, 16'd0, 1'b1, 2'd1, 1'b0, 10);
    check("R2", "still running", {31'd0, run_o}, 32'd1);
    // 2D with one row, loop flow
    run_xfer(32'h8000_0000, 16'd2, 16'd2, 16'd1, 16'd8, 1'b1, 2'd1, 1'b1, 100);

    for (int t = 0; t < 30; t++) begin
      logic [15:0] xm_pick;
      case ($urandom_range(0, 5))
        0: xm_pick = 16'd1;
        1: xm_pick = 16'd2;
        2: xm_pick = 16'd4;
        3: xm_pick = 16'hFFFF;
        4: xm_pick = 16'hFFFE;
        default: xm_pick = 16'hFFFC;
      endcase
      run_xfer($urandom, 16'($urandom_range(1, 6)), xm_pick,
               16'($urandom_range(1, 4)), 16'($urandom),
               1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), 200);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule